// File: doc/BRIEF.md
# Strobed memory cycle sequencer

This block drives an asynchronous byte-wide memory bus with a 19-bit address. A host hands it one command at a time through a valid/ready handshake: the opcode, a start address, a data byte and a length. The block then runs the bus cycle on its own. It drives the active-low memory-request, read and write strobes and the output enable for its data lines. When the command is finished it pulses a done flag. A read leaves the captured byte on a result port until the next read.

Besides single-byte reads and writes there are two burst modes. A fill burst writes one constant byte to a run of consecutive addresses. A block burst writes bytes taken from a valid/ready input stream. In both burst modes memory-request stays low for the whole burst. The address steps by one after each byte, and every byte gets its own write pulse. Strobe widths are fixed counts of clock cycles, set by parameters, and reads and writes use different counts.

Top module: `memcyc_seq`

## Requirements
- R1: After reset, `mreq_n`, `rd_n` and `wr_n` are high, `mem_dout_en` and `done` are low, and `cmd_ready` is high.
- R2: The 19-bit command address appears unchanged on `mem_addr`. Bit k of the address drives memory address line k, so bits 7:0 form the low byte, bits 15:8 the middle byte and bits 18:16 the top three lines.
- R3: During a write cycle, `mem_dout_en` is high and the data byte is driven for at least WR_SETUP (2) cycles before `wr_n` falls. `wr_n` then stays low for exactly WR_PULSE (2) cycles, and the data is stable throughout that low time.
- R4: During a read cycle, `rd_n` stays low for exactly RD_PULSE (3) cycles and `mem_dout_en` stays low. `rd_data` holds the byte present on `mem_din` in the last low cycle.
- R5: `rd_n` or `wr_n` is low only while `mreq_n` is low. `mreq_n` falls before the first strobe and rises only after the last strobe has returned high.
- R6: Each non-empty command produces exactly one low period of `mreq_n`. In bursts it stays low across all bytes.
- R7: A burst of length L produces exactly L write pulses, at address A, A+1, and so on. The address wraps modulo 2^19.
- R8: A fill burst writes the command data byte on every pulse.
- R9: A block burst writes stream bytes in the order they were accepted. While `strm_valid` is low, the sequencer waits with `mreq_n` low and no strobe active.
- R10: A fill or block command of length zero asserts `done` in the cycle after acceptance. It drives no strobe and no memory request.
- R11: `mem_dout_en` is high only during write commands and bursts. It is low for at least one cycle before `mreq_n` rises.
- R12: The opcode encoding is 0 read, 1 write, 2 fill, 3 block. The length is ignored for reads and writes. `cmd_ready` is high only when the block is idle. `done` pulses for one cycle when a command has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Idle, command can be taken |
| cmd_op | input | 2 | 0 read, 1 write, 2 fill, 3 block |
| cmd_addr | input | 19 | Start address |
| cmd_data | input | 8 | Write or fill byte |
| cmd_len | input | 16 | Burst length in bytes |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte captured by the last read |
| strm_valid | input | 1 | Stream byte offered (block mode) |
| strm_ready | output | 1 | Stream byte taken |
| strm_data | input | 8 | Stream byte |
| mem_addr | output | 19 | Memory address lines |
| mem_dout | output | 8 | Data driven to memory |
| mem_dout_en | output | 1 | Data line output enable |
| mem_din | input | 8 | Data read from memory |
| mreq_n | output | 1 | Memory request, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The hardest situation to reach is a block burst that starves mid-stream. The memory request must stay low across an arbitrary wait, and no stray pulse may appear while the next byte is missing. The bench's stream driver withholds valid at random and also forces a long gap at a chosen byte index. The bench then counts memory-request low periods and logs every write pulse. A second hard case is address wrap at the top of the 19-bit space, which the bench reaches with a directed fill that starts two bytes below the end.

// File: rtl/memcyc_pkg.sv
package memcyc_pkg;
   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_WRITE = 2'd1,
      OP_FILL  = 2'd2,
      OP_BLOCK = 2'd3
   } op_e;

   typedef enum logic [2:0] {
      S_IDLE, S_ADDR, S_FETCH, S_SETUP, S_STROBE, S_RECOV, S_END
   } seq_st_e;
endpackage

// File: rtl/memcyc_addr.sv
module memcyc_addr #(
   parameter int ADDR_W = 19,
   parameter int LEN_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [LEN_W-1:0]  load_len,
   input  logic              step,
   output logic [ADDR_W-1:0] addr,
   output logic              last
);
   logic [LEN_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr   <= '0;
         remain <= '0;
      end else if (load) begin
         addr   <= load_addr;
         remain <= load_len;
      end else if (step) begin
         addr   <= addr + 1'b1;
         remain <= remain - 1'b1;
      end
   end

   assign last = (remain <= LEN_W'(1));
endmodule

// File: rtl/memcyc_ctrl.sv
module memcyc_ctrl
   import memcyc_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int RD_SETUP = 1,
   parameter int RD_PULSE = 3,
   parameter int WR_SETUP = 2,
   parameter int WR_PULSE = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  op_e               cmd_op,
   input  logic [DATA_W-1:0] cmd_data,
   input  logic              len_zero,
   input  logic              strm_valid,
   input  logic [DATA_W-1:0] strm_data,
   input  logic [DATA_W-1:0] mem_din,
   input  logic              last,
   output logic              cmd_ready,
   output logic              load,
   output logic              step,
   output logic              done,
   output logic              strm_ready,
   output logic              mreq_n,
   output logic              rd_n,
   output logic              wr_n,
   output logic              dout_en,
   output logic [DATA_W-1:0] dout,
   output logic [DATA_W-1:0] rd_data
);
   localparam int MAX_A = (RD_SETUP > RD_PULSE) ? RD_SETUP : RD_PULSE;
   localparam int MAX_B = (WR_SETUP > WR_PULSE) ? WR_SETUP : WR_PULSE;
   localparam int MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int PH_W  = $clog2(MAX_D + 1);

   seq_st_e          st;
   op_e              op_q;
   logic [PH_W-1:0]  ph;
   logic [PH_W-1:0]  setup_end, pulse_end;
   logic             is_read, is_burst, in_req;

   assign is_read   = (op_q == OP_READ);
   assign is_burst  = (cmd_op == OP_FILL) || (cmd_op == OP_BLOCK);
   assign setup_end = is_read ? PH_W'(RD_SETUP - 1) : PH_W'(WR_SETUP - 1);
   assign pulse_end = is_read ? PH_W'(RD_PULSE - 1) : PH_W'(WR_PULSE - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         op_q    <= OP_READ;
         ph      <= '0;
         done    <= 1'b0;
         dout    <= '0;
         rd_data <= '0;
      end else begin
         done <= 1'b0;
         case (st)
            S_IDLE: if (cmd_valid) begin
               op_q <= cmd_op;
               dout <= cmd_data;
               if (is_burst && len_zero) done <= 1'b1;
               else                      st   <= S_ADDR;
            end
            S_ADDR: begin
               ph <= '0;
               st <= (op_q == OP_BLOCK) ? S_FETCH : S_SETUP;
            end
            S_FETCH: if (strm_valid) begin
               dout <= strm_data;
               ph   <= '0;
               st   <= S_SETUP;
            end
            S_SETUP: begin
               if (ph == setup_end) begin
                  ph <= '0;
                  st <= S_STROBE;
               end else ph <= ph + 1'b1;
            end
            S_STROBE: begin
               if (ph == pulse_end) begin
                  if (is_read) rd_data <= mem_din;
                  ph <= '0;
                  st <= S_RECOV;
               end else ph <= ph + 1'b1;
            end
            S_RECOV: begin
               ph <= '0;
               if (last)                      st <= S_END;
               else if (op_q == OP_BLOCK)     st <= S_FETCH;
               else                           st <= S_SETUP;
            end
            S_END: begin
               done <= 1'b1;
               st   <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign in_req     = (st == S_FETCH) || (st == S_SETUP) || (st == S_STROBE) ||
                       (st == S_RECOV) || (st == S_END);
   assign cmd_ready  = (st == S_IDLE);
   assign load       = (st == S_IDLE) && cmd_valid;
   assign step       = (st == S_RECOV) && !last;
   assign strm_ready = (st == S_FETCH);
   assign mreq_n     = !in_req;
   assign rd_n       = !(is_read && (st == S_STROBE));
   assign wr_n       = !(!is_read && (st == S_STROBE));
   assign dout_en    = !is_read &&
                       ((st == S_SETUP) || (st == S_STROBE) || (st == S_RECOV));
endmodule

// File: rtl/memcyc_seq.sv
module memcyc_seq
   import memcyc_pkg::*;
#(
   parameter int ADDR_W   = 19,
   parameter int DATA_W   = 8,
   parameter int LEN_W    = 16,
   parameter int RD_SETUP = 1,
   parameter int RD_PULSE = 3,
   parameter int WR_SETUP = 2,
   parameter int WR_PULSE = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [1:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_data,
   input  logic [LEN_W-1:0]  cmd_len,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   input  logic              strm_valid,
   output logic              strm_ready,
   input  logic [DATA_W-1:0] strm_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dout,
   output logic              mem_dout_en,
   input  logic [DATA_W-1:0] mem_din,
   output logic              mreq_n,
   output logic              rd_n,
   output logic              wr_n
);
   generate
      if (RD_SETUP < 1 || RD_PULSE < 1 || WR_SETUP < 1 || WR_PULSE < 1) begin : g_bad_timing
         $error("memcyc_seq: every setup and pulse count must be at least 1");
      end
      if (ADDR_W < 1 || DATA_W < 1 || LEN_W < 1) begin : g_bad_width
         $error("memcyc_seq: widths must be positive");
      end
   endgenerate

   op_e              op_in;
   logic             burst_in, len_zero, load, step, last;
   logic [LEN_W-1:0] eff_len;

   assign op_in    = op_e'(cmd_op);
   assign burst_in = (op_in == OP_FILL) || (op_in == OP_BLOCK);
   assign len_zero = (cmd_len == '0);
   assign eff_len  = burst_in ? cmd_len : LEN_W'(1);

   memcyc_addr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) addr_i (
      .clk(clk), .rst_n(rst_n), .load(load), .load_addr(cmd_addr),
      .load_len(eff_len), .step(step), .addr(mem_addr), .last(last)
   );

   memcyc_ctrl #(
      .DATA_W(DATA_W), .RD_SETUP(RD_SETUP), .RD_PULSE(RD_PULSE),
      .WR_SETUP(WR_SETUP), .WR_PULSE(WR_PULSE)
   ) ctrl_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(op_in),
      .cmd_data(cmd_data), .len_zero(len_zero), .strm_valid(strm_valid),
      .strm_data(strm_data), .mem_din(mem_din), .last(last),
      .cmd_ready(cmd_ready), .load(load), .step(step), .done(done),
      .strm_ready(strm_ready), .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n),
      .dout_en(mem_dout_en), .dout(mem_dout), .rd_data(rd_data)
   );
endmodule

// File: rtl/memcyc_seq_chk.sv
module memcyc_seq_chk #(
   parameter int RD_PULSE = 3,
   parameter int WR_PULSE = 2
) (
   input logic clk,
   input logic rst_n,
   input logic cmd_ready,
   input logic mreq_n,
   input logic rd_n,
   input logic wr_n,
   input logic mem_dout_en
);
   logic [7:0] wr_low, rd_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_low <= '0;
         rd_low <= '0;
      end else begin
         wr_low <= !wr_n ? wr_low + 8'd1 : 8'd0;
         rd_low <= !rd_n ? rd_low + 8'd1 : 8'd0;
      end
   end

   p_strobe_in_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n || !wr_n) |-> !mreq_n);
   p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));
   p_read_no_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !mem_dout_en);
   p_wr_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_n) |-> (wr_low == 8'(WR_PULSE)));
   p_rd_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_n) |-> (rd_low == 8'(RD_PULSE)));
   p_doe_before_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dout_en |=> !mreq_n);
   p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> (mreq_n && rd_n && wr_n && !mem_dout_en));
endmodule

bind memcyc_seq memcyc_seq_chk #(.RD_PULSE(RD_PULSE), .WR_PULSE(WR_PULSE)) chk_i (
   .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .mreq_n(mreq_n),
   .rd_n(rd_n), .wr_n(wr_n), .mem_dout_en(mem_dout_en)
);

// File: tb/memcyc_seq_tb_top.sv
module memcyc_seq_tb_top;
   localparam int WR_SETUP = 2;
   localparam int WR_PULSE = 2;
   localparam int RD_PULSE = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [1:0]  cmd_op = '0;
   logic [18:0] cmd_addr = '0;
   logic [7:0]  cmd_data = '0;
   logic [15:0] cmd_len = '0;
   logic        done;
   logic [7:0]  rd_data;
   logic        strm_valid = 1'b0;
   logic        strm_ready;
   logic [7:0]  strm_data = '0;
   logic [18:0] mem_addr;
   logic [7:0]  mem_dout;
   logic        mem_dout_en;
   logic [7:0]  mem_din;
   logic        mreq_n, rd_n, wr_n;

   int checks = 0;
   int failures = 0;

   logic [7:0]  bmem [512];
   logic [18:0] wlog_a [64];
   logic [7:0]  wlog_d [64];
   logic [7:0]  blk [64];
   int          wcount, req_starts, viol_strobe, viol_doe, wwidth_err, rwidth_err;
   int          wsetup_err, wdata_err, rdoe_err, ready_err, wdoe_cnt, wlen, rlen, doe_run;
   logic [18:0] rd_addr_seen;
   logic [7:0]  wcur_d;
   logic [18:0] wcur_a;
   logic        wr_p = 1'b1, rd_p = 1'b1, mreq_p = 1'b1, doe_p = 1'b0;

   logic        strm_on = 1'b0, fire_q = 1'b0;
   int          sidx = 0, stall_at = -1, stall_left = 0;

   always #4 clk = ~clk;

   assign mem_din = bmem[mem_addr[8:0]];

   memcyc_seq dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_len(cmd_len),
      .done(done), .rd_data(rd_data), .strm_valid(strm_valid), .strm_ready(strm_ready),
      .strm_data(strm_data), .mem_addr(mem_addr), .mem_dout(mem_dout),
      .mem_dout_en(mem_dout_en), .mem_din(mem_din), .mreq_n(mreq_n), .rd_n(rd_n),
      .wr_n(wr_n)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // bus monitor, sampled at the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (mreq_p && !mreq_n) req_starts++;
         if ((!rd_n || !wr_n) && mreq_n) viol_strobe++;
         if (!mem_dout_en && doe_p && mreq_p && mreq_n) viol_doe++;
         if (mem_dout_en && mreq_n) viol_doe++;
         if (!mreq_p && mreq_n && doe_p) viol_doe++;
         if (!wr_n) begin
            if (wr_p) begin
               wcur_a = mem_addr;
               wcur_d = mem_dout;
               if (doe_run < WR_SETUP) wsetup_err++;
               wlen = 0;
            end
            if (mem_dout !== wcur_d || mem_addr !== wcur_a || !mem_dout_en) wdata_err++;
            wlen++;
         end else if (!wr_p) begin
            if (wlen != WR_PULSE) wwidth_err++;
            bmem[wcur_a[8:0]] = wcur_d;
            if (wcount < 64) begin
               wlog_a[wcount] = wcur_a;
               wlog_d[wcount] = wcur_d;
            end
            wcount++;
         end
         if (!rd_n) begin
            if (rd_p) rlen = 0;
            rlen++;
            rd_addr_seen = mem_addr;
            if (mem_dout_en) rdoe_err++;
         end else if (!rd_p) begin
            if (rlen != RD_PULSE) rwidth_err++;
         end
         doe_run = mem_dout_en ? doe_run + 1 : 0;
         wr_p   = wr_n;
         rd_p   = rd_n;
         mreq_p = mreq_n;
         doe_p  = mem_dout_en;
      end
   end

   // stream source with random gaps and an optional forced stall
   always @(posedge clk) fire_q <= strm_valid && strm_ready;

   always @(negedge clk) begin
      if (!strm_on) begin
         strm_valid = 1'b0;
      end else begin
         if (fire_q) sidx++;
         if (fire_q || !strm_valid) begin
            if (sidx == stall_at && stall_left > 0) begin
               strm_valid = 1'b0;
               stall_left--;
            end else begin
               strm_valid = ($urandom % 4) != 0;
            end
         end
         strm_data = blk[sidx % 64];
      end
   end

   task automatic clear_mon();
      wcount = 0; req_starts = 0; viol_strobe = 0; viol_doe = 0;
      wwidth_err = 0; rwidth_err = 0; wsetup_err = 0; wdata_err = 0;
      rdoe_err = 0; ready_err = 0;
   endtask

   // issue one command and wait for its completion
   task automatic run_cmd(input logic [1:0] op, input logic [18:0] a,
                          input logic [7:0] d, input logic [15:0] len);
      int waited;
      bit zero;
      zero = (op >= 2) && (len == 0);
      clear_mon();
      @(negedge clk);
      check(cmd_ready === 1'b1, "R12 ready before command", cmd_ready, 1);
      sidx = 0;
      fire_q = 1'b0;
      strm_on = (op == 2'd3);
      cmd_op = op; cmd_addr = a; cmd_data = d; cmd_len = len; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      if (zero) begin
         check(done === 1'b1, "R10 zero length done next cycle", done, 1);
      end else begin
         waited = 0;
         while (done !== 1'b1 && waited < 2000) begin
            if (cmd_ready) ready_err++;
            @(negedge clk);
            waited++;
         end
         check(done === 1'b1, "R12 done pulse", done, 1);
      end
      @(negedge clk);
      check(done === 1'b0, "R12 done lasts one cycle", done, 0);
      strm_on = 1'b0;
      check(ready_err == 0, "R12 ready low while busy", ready_err, 0);
      check(req_starts == (zero ? 0 : 1), "R6 one request period", req_starts, zero ? 1'b0 : 1'b1);
      check(viol_strobe == 0, "R5 strobe only inside request", viol_strobe, 0);
      check(viol_doe == 0, "R11 enable drops before request rises", viol_doe, 0);
      check(wwidth_err == 0 && wdata_err == 0, "R3 write pulse width and data", wwidth_err + wdata_err, 0);
      check(wsetup_err == 0, "R3 data setup before strobe", wsetup_err, 0);
      check(rwidth_err == 0 && rdoe_err == 0, "R4 read pulse width, no drive", rwidth_err + rdoe_err, 0);
   endtask

   task automatic expect_writes(input logic [1:0] op, input logic [18:0] a,
                                input logic [7:0] d, input int n);
      logic [18:0] ea;
      logic [7:0]  ed;
      check(wcount == n, op == 2'd3 ? "R9 pulse count" : "R7 pulse count", wcount, n);
      for (int k = 0; k < n && k < 64; k++) begin
         ea = a + 19'(k);
         ed = (op == 2'd3) ? blk[k] : d;
         check(wlog_a[k] == ea, "R7 burst address step", wlog_a[k], ea);
         check(wlog_d[k] == ed, op == 2'd3 ? "R9 stream byte order" : "R8 constant data",
               wlog_d[k], ed);
      end
   endtask

   task automatic do_read(input logic [18:0] a);
      logic [7:0] exp;
      exp = bmem[a[8:0]];
      run_cmd(2'd0, a, 8'h00, 16'd7);
      check(rd_data == exp, "R4 read data", rd_data, exp);
      check(rd_addr_seen == a, "R2 read address lines", rd_addr_seen, a);
      check(wcount == 0, "R12 read ignores length", wcount, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      logic [1:0]  op;
      logic [18:0] a;
      logic [7:0]  d;
      logic [15:0] len;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 512; i++) bmem[i] = 8'(i * 7 + 3);
      for (int i = 0; i < 64; i++) blk[i] = 8'(i * 29 + 11);
      clear_mon();
      repeat (3) @(negedge clk);
      check(mreq_n === 1'b1 && rd_n === 1'b1 && wr_n === 1'b1, "R1 strobes idle in reset",
            {mreq_n, rd_n, wr_n}, 3'b111);
      rst_n = 1'b1;
      @(negedge clk);
      check(mem_dout_en === 1'b0 && done === 1'b0, "R1 enable and done low",
            {mem_dout_en, done}, 0);
      check(cmd_ready === 1'b1, "R1 ready after reset", cmd_ready, 1);

      // R2: address lines carry every bit in place
      run_cmd(2'd1, 19'h5A5A5, 8'hC3, 16'd9);
      expect_writes(2'd1, 19'h5A5A5, 8'hC3, 1);
      do_read(19'h5A5A5);
      run_cmd(2'd1, 19'h2A5A6, 8'h3C, 16'd0);
      expect_writes(2'd1, 19'h2A5A6, 8'h3C, 1);

      // R7: fill wraps at the top of the address space
      run_cmd(2'd2, 19'h7FFFE, 8'hE7, 16'd4);
      expect_writes(2'd2, 19'h7FFFE, 8'hE7, 4);
      do_read(19'h00001);

      // R10: empty bursts
      run_cmd(2'd2, 19'h00100, 8'h11, 16'd0);
      check(wcount == 0, "R10 no strobe on empty fill", wcount, 0);
      run_cmd(2'd3, 19'h00100, 8'h11, 16'd0);
      check(wcount == 0, "R10 no strobe on empty block", wcount, 0);

      // R9: block burst with a long forced stall mid-stream
      stall_at = 3; stall_left = 25;
      run_cmd(2'd3, 19'h01230, 8'h00, 16'd8);
      expect_writes(2'd3, 19'h01230, 8'h00, 8);
      stall_at = -1; stall_left = 0;

      // single byte burst
      run_cmd(2'd2, 19'h00042, 8'h99, 16'd1);
      expect_writes(2'd2, 19'h00042, 8'h99, 1);

      // random mix
      for (int n = 0; n < 40; n++) begin
         op  = 2'($urandom % 4);
         a   = 19'($urandom);
         if (($urandom % 5) == 0) a = 19'h7FFF0 + 19'($urandom % 16);
         d   = 8'($urandom);
         len = 16'($urandom % 21);
         if (op == 2'd0) begin
            do_read(a);
         end else begin
            run_cmd(op, a, d, len);
            expect_writes(op, a, d, (op == 2'd1) ? 1 : int'(len));
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule